// File: doc/BRIEF.md
# Interrupt-capable GPIO bank with word-register access

This block holds a parameterised bank of general-purpose lines (fewer than 32) behind a flat 32-bit register bus. The bus has an address, a write strobe, write data and combinational read data. Each access completes in a single cycle. Software chooses each line's direction and drives its output through separate set and clear strobe words. It reads a synchronised copy of the pins. The block exports the output value and output-enable vectors to pad logic outside the block.

Each line can raise an interrupt. A type bit picks edge or level detection and a polarity bit picks the active sense. An enable bit and a mask bit must both be 1 before a line can raise its pending bit. Edge pending bits hold until software acknowledges them. Level pending bits follow the live pin condition. All masked pending bits are ORed into one interrupt output. There is no native both-edge mode: software flips a line's polarity after each event to see the next transition in the other direction. A build parameter reverses the meaning of the direction word.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, `pin_out` is 0, `irq` is 0, and `pin_oe` is 0 when the direction word is not inverted.
- R2: The direction word at offset 0x00 drives `pin_oe`. With `INVERT_DIR`=0, a 1 makes a line an output. With `INVERT_DIR`=1, a 1 makes the line an input, so `pin_oe` is the complement of the word.
- R3: Writing offset 0x0C sets `pin_out` high for every 1 bit of the data. Lines whose data bit is 0 keep their value.
- R4: Writing offset 0x10 drives `pin_out` low for every 1 bit of the data. Lines whose data bit is 0 keep their value.
- R5: Offset 0x04 reads the pins through a two-flop synchroniser. A pin change made before a clock edge first appears in the read data after the second following edge.
- R6: With type bit 0 (offset 0x18), a line is edge sensitive. Polarity bit 1 (offset 0x1C) catches a rising edge and polarity bit 0 catches a falling edge. A transition in the opposite direction has no effect. A detected edge sets bit n of the pending word (offset 0x20) one edge after it reaches the input word.
- R7: An edge pending bit stays set until software writes 1 to that bit at offset 0x20. Writing 0 to a bit leaves it set.
- R8: With type bit 1, a line is level sensitive. Its pending bit reads 1 exactly while the synchronised pin equals its polarity bit, and it clears without any acknowledge.
- R9: A line sets its pending bit only when its enable bit (offset 0x14) and its mask bit (offset 0x24) are both 1.
- R10: `irq` is the OR of all pending bits ANDed with their mask bits. Clearing the mask bit of a line whose edge is still pending drops `irq`, and setting the mask bit again raises it.
- R11: Bits at positions NUM_LINES and above read 0 and writes to them are ignored. Unused offsets such as 0x08 read 0.
- R12: Rewriting a line's polarity to the inverse of its current input after an event lets the same line catch the next transition in the opposite direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the word being accessed |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | NUM_LINES | Asynchronous pin levels |
| pin_out | output | NUM_LINES | Output values toward the pads |
| pin_oe | output | NUM_LINES | Output enables toward the pads, 1 = drive |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the address and write strobe are steady around each rising edge. They also assume that each write lasts exactly one cycle, so the word a write leaves behind is visible on the next edge. The bench changes bus inputs and pins only on falling edges and raises the strobe for a single cycle per write. It holds each pin level for at least three edges, so the synchroniser and the edge detector always see a clean transition.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int OFF_DIR  = 'h00;
  localparam int OFF_IN   = 'h04;
  localparam int OFF_SET  = 'h0C;
  localparam int OFF_CLR  = 'h10;
  localparam int OFF_EN   = 'h14;
  localparam int OFF_TYPE = 'h18;
  localparam int OFF_POL  = 'h1C;
  localparam int OFF_PEND = 'h20;
  localparam int OFF_MASK = 'h24;

  // Write-one-to-set update of an output word
  function automatic logic [31:0] ones_set(input logic [31:0] cur, input logic [31:0] d,
                                           input logic [31:0] lanes);
    return cur | (d & lanes);
  endfunction

  // Write-one-to-clear update of an output word
  function automatic logic [31:0] ones_clear(input logic [31:0] cur, input logic [31:0] d,
                                             input logic [31:0] lanes);
    return cur & ~(d & lanes);
  endfunction

  // Transition in the selected direction between two samples
  function automatic logic edge_seen(input logic now_v, input logic old_v, input logic rise);
    return rise ? (now_v & ~old_v) : (~now_v & old_v);
  endfunction

  // Level equals the selected active sense
  function automatic logic level_seen(input logic now_v, input logic high);
    return now_v == high;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] cur_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stable_q;
  logic [WIDTH-1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      stable_q <= '0;
      hist_q   <= '0;
    end else begin
      meta_q   <= raw_i;
      stable_q <= meta_q;
      hist_q   <= stable_q;
    end
  end

  assign cur_o  = stable_q;
  assign prev_o = hist_q;
endmodule

// File: rtl/gpio_line_irq.sv
module gpio_line_irq
  import gpio_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cur_i,
  input  logic prev_i,
  input  logic level_sel_i,
  input  logic pol_i,
  input  logic armed_i,
  input  logic ack_i,
  output logic hit_o,
  output logic latch_o,
  output logic pend_o
);
  logic latch_q;

  assign hit_o = edge_seen(cur_i, prev_i, pol_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
    end else if (level_sel_i) begin
      latch_q <= 1'b0;
    end else if (hit_o && armed_i) begin
      latch_q <= 1'b1;
    end else if (ack_i) begin
      latch_q <= 1'b0;
    end
  end

  assign latch_o = latch_q;
  assign pend_o  = level_sel_i ? (armed_i & level_seen(cur_i, pol_i)) : latch_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_LINES  = 8,
  parameter bit INVERT_DIR = 1'b0,
  parameter int ADDR_W     = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] pin_in,
  output logic [NUM_LINES-1:0] pin_out,
  output logic [NUM_LINES-1:0] pin_oe,
  output logic                 irq
);
  localparam logic [31:0] LANES = (32'd1 << NUM_LINES) - 32'd1;

  if (NUM_LINES >= 32 || NUM_LINES < 1) begin : g_bad_width
    $error("NUM_LINES must be between 1 and 31");
  end

  logic [31:0] dir_q, out_q, en_q, type_q, pol_q, mask_q;
  logic [NUM_LINES-1:0] in_cur, in_prev;
  logic [31:0] edge_pend, pend_vec, hit_vec;

  // Named write events
  logic wr_dir, wr_set, wr_clr, wr_en, wr_type, wr_pol, wr_pend, wr_mask;
  assign wr_dir  = bus_we && (bus_addr == ADDR_W'(OFF_DIR));
  assign wr_set  = bus_we && (bus_addr == ADDR_W'(OFF_SET));
  assign wr_clr  = bus_we && (bus_addr == ADDR_W'(OFF_CLR));
  assign wr_en   = bus_we && (bus_addr == ADDR_W'(OFF_EN));
  assign wr_type = bus_we && (bus_addr == ADDR_W'(OFF_TYPE));
  assign wr_pol  = bus_we && (bus_addr == ADDR_W'(OFF_POL));
  assign wr_pend = bus_we && (bus_addr == ADDR_W'(OFF_PEND));
  assign wr_mask = bus_we && (bus_addr == ADDR_W'(OFF_MASK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      en_q   <= '0;
      type_q <= '0;
      pol_q  <= '0;
      mask_q <= '0;
    end else begin
      if (wr_dir)  dir_q  <= bus_wdata & LANES;
      if (wr_set)  out_q  <= ones_set(out_q, bus_wdata, LANES);
      if (wr_clr)  out_q  <= ones_clear(out_q, bus_wdata, LANES);
      if (wr_en)   en_q   <= bus_wdata & LANES;
      if (wr_type) type_q <= bus_wdata & LANES;
      if (wr_pol)  pol_q  <= bus_wdata & LANES;
      if (wr_mask) mask_q <= bus_wdata & LANES;
    end
  end

  gpio_in_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (pin_in),
    .cur_o  (in_cur),
    .prev_o (in_prev)
  );

  for (genvar i = 0; i < 32; i++) begin : g_line
    if (i < NUM_LINES) begin : g_live
      gpio_line_irq u_line (
        .clk         (clk),
        .rst_n       (rst_n),
        .cur_i       (in_cur[i]),
        .prev_i      (in_prev[i]),
        .level_sel_i (type_q[i]),
        .pol_i       (pol_q[i]),
        .armed_i     (en_q[i] & mask_q[i]),
        .ack_i       (wr_pend & bus_wdata[i]),
        .hit_o       (hit_vec[i]),
        .latch_o     (edge_pend[i]),
        .pend_o      (pend_vec[i])
      );
    end else begin : g_tie
      assign hit_vec[i]   = 1'b0;
      assign edge_pend[i] = 1'b0;
      assign pend_vec[i]  = 1'b0;
    end
  end

  assign irq     = |(pend_vec & mask_q);
  assign pin_out = out_q[NUM_LINES-1:0];
  assign pin_oe  = INVERT_DIR ? ~dir_q[NUM_LINES-1:0] : dir_q[NUM_LINES-1:0];

  always_comb begin
    bus_rdata = '0;
    case (32'(bus_addr))
      OFF_DIR:          bus_rdata = dir_q;
      OFF_IN:           bus_rdata = 32'(in_cur);
      OFF_SET, OFF_CLR: bus_rdata = out_q;
      OFF_EN:           bus_rdata = en_q;
      OFF_TYPE:         bus_rdata = type_q;
      OFF_POL:          bus_rdata = pol_q;
      OFF_PEND:         bus_rdata = pend_vec;
      OFF_MASK:         bus_rdata = mask_q;
      default:          bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int NUM_LINES  = 8,
  parameter bit INVERT_DIR = 1'b0,
  parameter int ADDR_W     = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_we,
  input logic [NUM_LINES-1:0] wlanes,
  input logic [NUM_LINES-1:0] pin_in,
  input logic [NUM_LINES-1:0] pin_out,
  input logic [NUM_LINES-1:0] pin_oe,
  input logic [NUM_LINES-1:0] in_cur,
  input logic                 irq,
  input logic [31:0]          en_q,
  input logic [31:0]          mask_q,
  input logic [31:0]          edge_pend
);
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  p_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFF_DIR)) |=>
      (pin_oe == (INVERT_DIR ? ~$past(wlanes) : $past(wlanes))));

  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFF_SET)) |=> ((pin_out & $past(wlanes)) == $past(wlanes)));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFF_CLR)) |=> ((pin_out & $past(wlanes)) == '0));

  p_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (in_cur == $past(pin_in, 2)));

  p_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0) |-> (((edge_pend & ~$past(edge_pend)) & ~$past(en_q & mask_q)) == 32'd0));

  p_irq_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != 32'd0));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
  .NUM_LINES(NUM_LINES), .INVERT_DIR(INVERT_DIR), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .wlanes(bus_wdata[NUM_LINES-1:0]), .pin_in(pin_in), .pin_out(pin_out),
  .pin_oe(pin_oe), .in_cur(in_cur), .irq(irq), .en_q(en_q),
  .mask_q(mask_q), .edge_pend(edge_pend)
);

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
  localparam int N = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] addr = '0, addr_i = '0;
  logic we = 1'b0, we_i = 1'b0;
  logic [31:0] wdata = '0, wdata_i = '0;
  logic [31:0] rdata, rdata_i;
  logic [N-1:0] pins = '0;
  logic [N-1:0] pout, poe, pout_i, poe_i;
  logic irq, irq_i;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_ctrl #(.NUM_LINES(N), .INVERT_DIR(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .pin_in(pins), .pin_out(pout), .pin_oe(poe), .irq(irq));

  gpio_irq_ctrl #(.NUM_LINES(N), .INVERT_DIR(1'b1)) uut_inv (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr_i), .bus_we(we_i), .bus_wdata(wdata_i),
    .bus_rdata(rdata_i), .pin_in(pins), .pin_out(pout_i), .pin_oe(poe_i), .irq(irq_i));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic waitn(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic quiet();
    wr(6'h14, 0); wr(6'h18, 0); wr(6'h1C, 0); wr(6'h24, 0);
    @(negedge clk); pins = '0; waitn(3);
    wr(6'h20, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a <= 'h24; a += 4) begin
      rd(6'(a), v); check("R1 reg", v, 0);
    end
    check("R1 pin_out", 32'(pout), 0);
    check("R1 pin_oe", 32'(poe), 0);
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_dir();
    logic [31:0] v;
    wr(6'h00, 32'hFFFF_FFA5);
    check("R2 oe normal", 32'(poe), 32'hA5);
    rd(6'h00, v); check("R11 dir upper bits", v, 32'hA5);
    @(negedge clk); addr_i = 6'h00; wdata_i = 32'h0F; we_i = 1'b1;
    @(negedge clk); we_i = 1'b0;
    check("R2 oe inverted", 32'(poe_i), 32'hF0);
  endtask

  task automatic t_setclr();
    logic [31:0] v;
    wr(6'h0C, 32'h81); check("R3 set", 32'(pout), 32'h81);
    wr(6'h0C, 32'h02); check("R3 set keeps zeros", 32'(pout), 32'h83);
    wr(6'h10, 32'h01); check("R4 clear", 32'(pout), 32'h82);
    wr(6'h10, 32'h00); check("R4 clear zero no effect", 32'(pout), 32'h82);
    wr(6'h0C, 32'hFFFF_FF00); check("R11 set upper ignored", 32'(pout), 32'h82);
    rd(6'h08, v); check("R11 unused offset", v, 0);
  endtask

  task automatic t_input();
    logic [31:0] v;
    @(negedge clk); pins = 8'h5A;
    @(negedge clk); rd(6'h04, v); check("R5 after one edge", v, 0);
    @(negedge clk); rd(6'h04, v); check("R5 after two edges", v, 32'h5A);
    quiet();
  endtask

  task automatic t_edge();
    logic [31:0] v;
    wr(6'h1C, 32'h01); wr(6'h14, 32'h03); wr(6'h24, 32'h03);
    @(negedge clk); pins[0] = 1'b1; waitn(3);
    rd(6'h20, v); check("R6 rising caught", v, 32'h01);
    check("R10 irq on pending", 32'(irq), 1);
    @(negedge clk); pins[1] = 1'b1; waitn(3);
    rd(6'h20, v); check("R6 wrong direction ignored", v, 32'h01);
    @(negedge clk); pins[1] = 1'b0; waitn(3);
    rd(6'h20, v); check("R6 falling caught", v, 32'h03);
    @(negedge clk); pins[0] = 1'b0; waitn(3);
    rd(6'h20, v); check("R7 held after input returns", v, 32'h03);
    wr(6'h20, 32'h00); rd(6'h20, v); check("R7 zero write keeps", v, 32'h03);
    wr(6'h20, 32'h01); rd(6'h20, v); check("R7 ack one line", v, 32'h02);
    wr(6'h24, 32'h01); check("R10 masked pending drops irq", 32'(irq), 0);
    wr(6'h24, 32'h03); check("R10 unmask raises irq", 32'(irq), 1);
    wr(6'h20, 32'h02); rd(6'h20, v); check("R7 ack second line", v, 0);
    check("R10 irq idle", 32'(irq), 0);
    quiet();
  endtask

  task automatic t_gate();
    logic [31:0] v;
    wr(6'h1C, 32'h0C); wr(6'h14, 32'h04); wr(6'h24, 32'h08);
    @(negedge clk); pins[3:2] = 2'b11; waitn(3);
    rd(6'h20, v); check("R9 needs enable and mask", v, 0);
    check("R9 no irq", 32'(irq), 0);
    quiet();
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(6'h18, 32'h10); wr(6'h1C, 32'h10); wr(6'h14, 32'h10); wr(6'h24, 32'h10);
    rd(6'h20, v); check("R8 inactive level", v, 0);
    @(negedge clk); pins[4] = 1'b1; waitn(2);
    rd(6'h20, v); check("R8 high level pending", v, 32'h10);
    check("R8 irq", 32'(irq), 1);
    @(negedge clk); pins[4] = 1'b0; waitn(2);
    rd(6'h20, v); check("R8 follows input", v, 0);
    wr(6'h1C, 32'h00); rd(6'h20, v); check("R8 low level pending", v, 32'h10);
    quiet();
  endtask

  task automatic t_both();
    logic [31:0] v, inw;
    wr(6'h1C, 32'h20); wr(6'h14, 32'h20); wr(6'h24, 32'h20);
    @(negedge clk); pins[5] = 1'b1; waitn(3);
    rd(6'h20, v); check("R12 first edge", v, 32'h20);
    rd(6'h04, inw);
    wr(6'h1C, ~inw & 32'h20); wr(6'h20, 32'h20);
    rd(6'h20, v); check("R12 acked", v, 0);
    @(negedge clk); pins[5] = 1'b0; waitn(3);
    rd(6'h20, v); check("R12 opposite edge", v, 32'h20);
    quiet();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    waitn(3);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_dir();
    t_setclr();
    t_input();
    t_edge();
    t_gate();
    t_level();
    t_both();
    finish_run();
  end
endmodule